// File: doc/BRIEF.md
# Serial-Load LED Sink Driver Control Core

This block holds the control logic of a sixteen-channel LED sink driver. A host feeds pixel bits one at a time into a serial input. Each rising edge of the shift clock moves them along a chain of flip-flops, and the last stage drives a serial output. Several drivers can therefore be daisy-chained on one data line. A latch-enable input copies the chain into a display register. The copy is transparent while the enable is high and frozen while it is low. An active-low output-enable then gates the sixteen channel-on signals.

Two protection inputs protect the display. The first is a logic-supply undervoltage flag. While it is asserted, every channel is blanked and all stored bits are cleared, so the display restarts from a known empty state. The second is a junction temperature code in degrees Celsius. When it crosses a trip point, the channels are blanked with hysteresis, and data entry carries on so that the picture returns intact once the die has cooled.

Top module: `ledsink_core`

## Requirements
- R1: On every rising `clk` edge without reset or undervoltage, `sdi` enters chain bit 0 and each chain bit k moves to bit k+1.
- R2: `sdo` always equals chain bit 15, so a bit presented to `sdi` on edge n appears on `sdo` after edge n+15.
- R3: While `le` is high, the display register equals the current chain contents, including right after each edge.
- R4: While `le` is low, the display register keeps the value it had at the last edge at which `le` was high.
- R5: With `oe_n` high all `out_on` bits are 0. With `oe_n` low, `out_on[k]` equals display bit k, provided no protection is active.
- R6: The level of `oe_n` never changes the chain or the display register.
- R7: A synchronous active-high `rst` clears the chain, the display register and the thermal flag on the next edge.
- R8: While `uv` is high, `out_on` is 0 at once, and every edge clears the chain and the display register. After release, shifting resumes from all zeros.
- R9: A `temp_c` value of 165 or more, sampled at an edge, forces `out_on` to 0 from that edge onward.
- R10: Once tripped, the outputs stay blanked until a sampled `temp_c` of 150 or less. Between 151 and 164 the flag holds its current state in both directions.
- R11: During thermal blanking, the chain keeps shifting and the display register keeps following `le`, so the new data shows on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Display register transparent when high |
| oe_n | input | 1 | Active-low output enable |
| uv | input | 1 | Logic supply undervoltage flag |
| temp_c | input | 8 | Junction temperature, unsigned degrees Celsius |
| sdo | output | 1 | Serial data out (chain bit 15) |
| out_on | output | 16 | Channel on commands |

## Verification
The hardest condition to reach from the ports is the band between 151 and 164 degrees. There the thermal flag must remember which side it came from, so the same input value requires opposite outputs. The stimulus loads a known pattern into the display register and holds `oe_n` low. It then ramps `temp_c` over all 256 codes upward and then downward, checking `out_on` at every step. Each code in the band is therefore seen once with the flag clear and once with it set. A second case sends fresh data through the chain while the part is tripped, and checks that the data appears once it cools.

// File: rtl/ledsink_pkg.sv
package ledsink_pkg;

    typedef enum logic {
        TH_RUN  = 1'b0,
        TH_TRIP = 1'b1
    } therm_state_t;

    typedef struct packed {
        logic clear;
        logic oe_n;
        logic trip;
        logic uv;
    } gate_ctl_t;

    function automatic therm_state_t next_therm(therm_state_t cur, logic hot, logic cool);
        therm_state_t nxt;
        nxt = cur;
        if (hot)
            nxt = TH_TRIP;
        else if (cool)
            nxt = TH_RUN;
        return nxt;
    endfunction

    function automatic logic blanked(gate_ctl_t c);
        return c.oe_n | c.trip | c.uv;
    endfunction

endpackage

// File: rtl/ledsink_shifter.sv
module ledsink_shifter #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         sdi,
    output logic [N-1:0] chain_q,
    output logic [N-1:0] chain_d
);
    always_comb begin
        if (clear)
            chain_d = '0;
        else
            chain_d = {chain_q[N-2:0], sdi};
    end

    always_ff @(posedge clk) begin
        chain_q <= chain_d;
    end
endmodule

// File: rtl/ledsink_latch.sv
module ledsink_latch #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         clear,
    input  logic         le,
    input  logic [N-1:0] chain_q,
    input  logic [N-1:0] chain_d,
    output logic [N-1:0] hold_q,
    output logic [N-1:0] disp
);
    always_ff @(posedge clk) begin
        if (clear)
            hold_q <= '0;
        else if (le)
            hold_q <= chain_d;
    end

    always_comb begin
        disp = le ? chain_q : hold_q;
    end
endmodule

// File: rtl/ledsink_thermal.sv
module ledsink_thermal
    import ledsink_pkg::*;
#(
    parameter int unsigned TW      = 8,
    parameter int unsigned TRIP    = 165,
    parameter int unsigned RELEASE = 150
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] temp,
    output logic          trip
);
    localparam logic [TW-1:0] TRIP_C = TW'(TRIP);
    localparam logic [TW-1:0] REL_C  = TW'(RELEASE);

    therm_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= TH_RUN;
        else
            st_q <= next_therm(st_q, temp >= TRIP_C, temp <= REL_C);
    end

    assign trip = (st_q == TH_TRIP);
endmodule

// File: rtl/ledsink_gate.sv
module ledsink_gate
    import ledsink_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  gate_ctl_t    ctl,
    input  logic [N-1:0] disp,
    output logic [N-1:0] out_on
);
    for (genvar k = 0; k < N; k++) begin : g_ch
        assign out_on[k] = disp[k] & ~blanked(ctl);
    end
endmodule

// File: rtl/ledsink_core.sv
module ledsink_core
    import ledsink_pkg::*;
#(
    parameter int unsigned N       = 16,
    parameter int unsigned TW      = 8,
    parameter int unsigned TRIP    = 165,
    parameter int unsigned RELEASE = 150
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sdi,
    input  logic          le,
    input  logic          oe_n,
    input  logic          uv,
    input  logic [TW-1:0] temp_c,
    output logic          sdo,
    output logic [N-1:0]  out_on
);
    logic [N-1:0] chain_q, chain_d, hold_q, disp;
    logic         trip;
    gate_ctl_t    ctl;

    assign ctl.clear = rst | uv;
    assign ctl.oe_n  = oe_n;
    assign ctl.trip  = trip;
    assign ctl.uv    = uv;

    ledsink_shifter #(.N(N)) u_shift (
        .clk(clk), .clear(ctl.clear), .sdi(sdi),
        .chain_q(chain_q), .chain_d(chain_d)
    );

    ledsink_latch #(.N(N)) u_latch (
        .clk(clk), .clear(ctl.clear), .le(le),
        .chain_q(chain_q), .chain_d(chain_d),
        .hold_q(hold_q), .disp(disp)
    );

    ledsink_thermal #(.TW(TW), .TRIP(TRIP), .RELEASE(RELEASE)) u_therm (
        .clk(clk), .rst(rst), .temp(temp_c), .trip(trip)
    );

    ledsink_gate #(.N(N)) u_gate (
        .ctl(ctl), .disp(disp), .out_on(out_on)
    );

    assign sdo = chain_q[N-1];
endmodule

// File: rtl/ledsink_core_chk.sv
module ledsink_core_chk #(
    parameter int unsigned N       = 16,
    parameter int unsigned TW      = 8,
    parameter int unsigned TRIP    = 165,
    parameter int unsigned RELEASE = 150
) (
    input logic          clk,
    input logic          rst,
    input logic          sdi,
    input logic          le,
    input logic          oe_n,
    input logic          uv,
    input logic [TW-1:0] temp_c,
    input logic [N-1:0]  out_on,
    input logic [N-1:0]  chain_q,
    input logic [N-1:0]  hold_q,
    input logic          trip
);
    logic armed_q;
    always_ff @(posedge clk) armed_q <= !rst;

    assert_shift_R1: assert property (@(posedge clk) disable iff (rst)
        (!uv) |=> (chain_q[0] == $past(sdi)) && (chain_q[N-1:1] == $past(chain_q[N-2:0])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !le && !uv) |=> $stable(hold_q));

    assert_oe_off_R5: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (out_on == '0));

    assert_uv_off_R8: assert property (@(posedge clk) disable iff (rst)
        uv |-> (out_on == '0));

    assert_uv_clear_R8: assert property (@(posedge clk) disable iff (rst)
        uv |=> (chain_q == '0) && (hold_q == '0));

    assert_trip_R9: assert property (@(posedge clk) disable iff (rst)
        (temp_c >= TW'(TRIP)) |=> (trip && out_on == '0));

    assert_keep_R10: assert property (@(posedge clk) disable iff (rst)
        (armed_q && trip && temp_c > TW'(RELEASE)) |=> trip);

    assert_no_early_R10: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !trip && temp_c < TW'(TRIP)) |=> !trip);
endmodule

bind ledsink_core ledsink_core_chk #(.N(N), .TW(TW), .TRIP(TRIP), .RELEASE(RELEASE)) u_chk (
    .clk(clk), .rst(rst), .sdi(sdi), .le(le), .oe_n(oe_n), .uv(uv),
    .temp_c(temp_c), .out_on(out_on), .chain_q(chain_q), .hold_q(hold_q), .trip(trip)
);

// File: tb/test_ledsink_core.sv
module test_ledsink_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sdi = 1'b0;
    logic        le = 1'b0;
    logic        oe_n = 1'b1;
    logic        uv = 1'b0;
    logic [7:0]  temp_c = 8'd25;
    logic        sdo;
    logic [15:0] out_on;

    int tests = 0;
    int fails = 0;

    logic [15:0] m_chain = '0;
    logic [15:0] m_hold = '0;
    logic        m_trip = 1'b0;

    always #10 clk = ~clk;

    ledsink_core i_ledsink_core (
        .clk(clk), .rst(rst), .sdi(sdi), .le(le), .oe_n(oe_n), .uv(uv),
        .temp_c(temp_c), .sdo(sdo), .out_on(out_on)
    );

    function automatic logic [15:0] exp_out();
        logic [15:0] d;
        d = le ? m_chain : m_hold;
        return (oe_n || uv || m_trip) ? 16'h0 : d;
    endfunction

    task automatic check(string tag);
        tests++;
        if (out_on !== exp_out() || sdo !== m_chain[15]) begin
            fails++;
            $display("FAIL %s: out_on=%h sdo=%b expected out_on=%h sdo=%b",
                     tag, out_on, sdo, exp_out(), m_chain[15]);
        end
    endtask

    task automatic step(string tag, logic d, logic l, logic o, logic u, logic [7:0] t);
        sdi = d; le = l; oe_n = o; uv = u; temp_c = t;
        #2;
        check(tag);
        @(posedge clk);
        if (rst || u) begin
            m_chain = '0;
            m_hold  = '0;
        end else begin
            m_chain = {m_chain[14:0], d};
            if (l) m_hold = m_chain;
        end
        if (rst) m_trip = 1'b0;
        else if (t >= 8'd165) m_trip = 1'b1;
        else if (t <= 8'd150) m_trip = 1'b0;
        @(negedge clk);
        check(tag);
    endtask

    task automatic load(string tag, logic [15:0] w, logic o, logic [7:0] t);
        for (int i = 15; i >= 0; i--) step(tag, w[i], 1'b0, o, 1'b0, t);
        step(tag, 1'b0, 1'b1, o, 1'b0, t);
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        @(negedge clk);
        rst = 1'b1;
        step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 8'd200);
        step("R7", 1'b1, 1'b1, 1'b0, 1'b0, 8'd25);
        rst = 1'b0;
        check("R7");

        // R1 R2 R4: shift patterns with le low, display stays at zero
        lf = 16'hACE1;
        for (int p = 0; p < 24; p++) begin
            for (int i = 0; i < 16; i++) step("R2", lf[i], 1'b0, 1'b0, 1'b0, 8'd40);
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        end
        // R3: transparent display while le is high for several edges
        for (int i = 0; i < 20; i++) step("R3", lf[i % 16], 1'b1, 1'b0, 1'b0, 8'd40);
        // R4: freeze, then shift more
        for (int i = 0; i < 20; i++) step("R4", ~lf[i % 16], 1'b0, 1'b0, 1'b0, 8'd40);
        // R5 R6: oe_n high blanks and leaves storage alone
        load("R5", 16'h5A3C, 1'b1, 8'd40);
        for (int i = 0; i < 5; i++) step("R6", 1'b0, 1'b0, 1'b1, 1'b0, 8'd40);
        step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 8'd40);
        for (int i = 0; i < 4; i++) step("R5", 1'b1, 1'b0, i[0], 1'b0, 8'd40);
        // R8: undervoltage
        load("R8", 16'hFFFF, 1'b0, 8'd40);
        step("R8", 1'b1, 1'b1, 1'b0, 1'b1, 8'd40);
        step("R8", 1'b1, 1'b0, 1'b0, 1'b1, 8'd40);
        for (int i = 0; i < 17; i++) step("R8", i == 0, 1'b1, 1'b0, 1'b0, 8'd40);
        // R9 R10: full ramp up and down with pattern displayed
        load("R9", 16'hC3A5, 1'b0, 8'd40);
        for (int t = 0; t < 256; t++) step("R9", 1'b0, 1'b0, 1'b0, 1'b0, 8'(t));
        for (int t = 255; t >= 0; t--) step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 8'(t));
        step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 8'd170);
        for (int t = 164; t >= 151; t--) step("R10", 1'b0, 1'b0, 1'b0, 1'b0, 8'(t));
        // R11: new data loaded during trip appears on release
        load("R11", 16'h0F96, 1'b0, 8'd158);
        step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 8'd150);
        step("R11", 1'b0, 1'b0, 1'b0, 1'b0, 8'd30);
        // R7: reset in mid-operation
        rst = 1'b1;
        step("R7", 1'b1, 1'b0, 1'b0, 1'b0, 8'd30);
        rst = 1'b0;
        step("R7", 1'b0, 1'b1, 1'b0, 1'b0, 8'd30);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule